// File: doc/BRIEF.md
# Scrolling Digit Seven-Segment Controller

This block drives a four-digit, common-anode seven-segment display so that a fixed ring of eight decimal digits crawls across it, one position per scroll interval. A fast scan tick turns the digits on one at a time. A slow scroll tick, taken from the scan tick, rotates the ring of digits. Both ticks come from one system clock as single-cycle enables. Nothing is gated on a clock.

All output lines are active low. The digit-enable pattern is the only select for the digit that reaches the segment decoder, so the segments always belong to the digit that is lit. The block has no data stream, so it has no valid/ready handshake. Its pins are plain control and display lines. Both divider limits are parameters. The defaults give a 1 kHz scan and a 1 Hz scroll from a 100 MHz clock.

Top module: `scroll_seg_display`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears both dividers and the scan state. It reloads the ring with its starting order. After that edge `dig_en_n` is 1111 and `seg_n` is 1111111.
- R2: The scan tick fires once every `SCAN_DIV` clocks. After reset is released, `dig_en_n` first changes after edge `SCAN_DIV+1`, and then again every `SCAN_DIV` edges.
- R3: The scroll tick fires once for every `SCROLL_DIV` scan ticks. The ring first rotates after edge `SCAN_DIV*SCROLL_DIV+2` following reset release, and then every `SCAN_DIV*SCROLL_DIV` edges.
- R4: On each scan tick, `dig_en_n` steps 1111 -> 1110 -> 1101 -> 1011 -> 0111 -> 1110, and the cycle repeats. 1111 is seen only after reset.
- R5: At most one bit of `dig_en_n` is low at any time.
- R6: When every bit of `dig_en_n` is high, `seg_n` is 1111111.
- R7: The ring has eight 4-bit slots. Reset loads slot 0..7 with 1,2,3,4,5,6,7,0. Each rotation moves slot 0 to slot 7 and shifts every other slot down by one. For example, 1 2 3 4 5 6 7 0 becomes 2 3 4 5 6 7 0 1.
- R8: When bit k of `dig_en_n` is low, the segments show slot 3-k. Bit 3 therefore shows slot 0, so the display reads slots 0..3 from left to right. The segments follow the enable in the same cycle.
- R9: `seg_n` is active low with bit order g,f,e,d,c,b,a (bit 6 = g, bit 0 = a). The codes are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000, 8=0000000, 9=0010000. Any other value blanks the display.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dig_en_n | output | 4 | Digit enables, active low, bit 3 = leftmost digit |
| seg_n | output | 7 | Segment lines, active low, bit 6 = g down to bit 0 = a |

## Verification
Counting from the first edge after reset release, the digit enable moves after edge `SCAN_DIV+1`. This is one edge later than the scan tick, because the tick and then the enable are each registered. The first rotation is seen after edge `SCAN_DIV*SCROLL_DIV+2`, one edge later than the scan-enable step, because the scroll tick adds a register. The segments are combinational from the enable and the ring, so they change in the same cycle as those. The bench counts edges from reset release and samples on the falling edge after the edge count for each row. Some rows sit exactly on a step or rotation edge, so an error of one cycle in either direction moves the sample onto the wrong digit.

// File: rtl/scroll_seg_pkg.sv
package scroll_seg_pkg;

  localparam int unsigned NIB_W = 4;
  localparam int unsigned SEG_W = 7;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_BLANK = 7'b1111111;

  // active-low, bit 6 = g ... bit 0 = a
  function automatic seg_t nib_to_seg(input nib_t v);
    seg_t s;
    case (v)
      4'd0:    s = 7'b1000000;
      4'd1:    s = 7'b1111001;
      4'd2:    s = 7'b0100100;
      4'd3:    s = 7'b0110000;
      4'd4:    s = 7'b0011001;
      4'd5:    s = 7'b0010010;
      4'd6:    s = 7'b0000010;
      4'd7:    s = 7'b1111000;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0010000;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ssd_tick_div.sv
// Counts qualified steps; emits a registered one-cycle pulse as the count wraps.
module ssd_tick_div #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic pulse
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else if (step) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        pulse <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/ssd_digit_ring.sv
// Circular digit store; slot i starts at (i+1) mod SLOTS and rotates toward slot 0.
module ssd_digit_ring
  import scroll_seg_pkg::*;
#(
  parameter int unsigned SLOTS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  roll,
  output nib_t [SLOTS-1:0]      slots
);
  nib_t [SLOTS-1:0] ring_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam nib_t INIT = NIB_W'((i + 1) % SLOTS);
    localparam int unsigned NEXT = (i + 1) % SLOTS;
    always_ff @(posedge clk) begin
      if (rst)       ring_q[i] <= INIT;
      else if (roll) ring_q[i] <= ring_q[NEXT];
    end
  end

  assign slots = ring_q;
endmodule

// File: rtl/ssd_scan_seq.sv
// One-cold digit scan; all-off after reset, first advance selects digit 0.
module ssd_scan_seq #(
  parameter int unsigned DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [DIGITS-1:0] en_n
);
  logic [DIGITS-1:0] hot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q <= '0;
    end else if (adv) begin
      if (hot_q == '0 || hot_q[DIGITS-1])
        hot_q <= DIGITS'(1);
      else
        hot_q <= hot_q << 1;
    end
  end

  assign en_n = ~hot_q;
endmodule

// File: rtl/ssd_seg_select.sv
// Enable pattern picks the slot; decoder drives segments, blank when idle.
module ssd_seg_select
  import scroll_seg_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  parameter int unsigned SLOTS  = 8
) (
  input  logic [DIGITS-1:0]  en_n,
  input  nib_t [SLOTS-1:0]   slots,
  output seg_t               seg_n
);
  nib_t pick;

  always_comb begin
    pick = '0;
    for (int k = 0; k < DIGITS; k++) begin
      if (!en_n[k]) pick = pick | slots[DIGITS-1-k];
    end
  end

  assign seg_n = (&en_n) ? SEG_BLANK : nib_to_seg(pick);
endmodule

// File: rtl/scroll_seg_display.sv
module scroll_seg_display
  import scroll_seg_pkg::*;
#(
  parameter int unsigned SCAN_DIV   = 100000,
  parameter int unsigned SCROLL_DIV = 1000,
  parameter int unsigned DIGITS     = 4,
  parameter int unsigned SLOTS      = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DIGITS-1:0] dig_en_n,
  output logic [SEG_W-1:0]  seg_n
);
  logic             scan_tick;
  logic             roll_tick;
  nib_t [SLOTS-1:0] slots;

  ssd_tick_div #(.LIMIT(SCAN_DIV)) scan_div_i (
    .clk(clk), .rst(rst), .step(1'b1), .pulse(scan_tick)
  );

  ssd_tick_div #(.LIMIT(SCROLL_DIV)) roll_div_i (
    .clk(clk), .rst(rst), .step(scan_tick), .pulse(roll_tick)
  );

  ssd_digit_ring #(.SLOTS(SLOTS)) ring_i (
    .clk(clk), .rst(rst), .roll(roll_tick), .slots(slots)
  );

  ssd_scan_seq #(.DIGITS(DIGITS)) scan_i (
    .clk(clk), .rst(rst), .adv(scan_tick), .en_n(dig_en_n)
  );

  ssd_seg_select #(.DIGITS(DIGITS), .SLOTS(SLOTS)) sel_i (
    .en_n(dig_en_n), .slots(slots), .seg_n(seg_n)
  );
endmodule

// File: rtl/scroll_seg_checker.sv
module scroll_seg_checker #(
  parameter int unsigned DIGITS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DIGITS-1:0] dig_en_n,
  input logic [6:0]        seg_n,
  input logic              scan_tick,
  input logic              roll_tick
);
  logic [DIGITS-1:0] en_q;
  always_ff @(posedge clk) en_q <= dig_en_n;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (dig_en_n == '1 && seg_n == 7'b1111111));

  assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(dig_en_n) |-> $past(scan_tick));

  assert_roll_from_scan_R3: assert property (@(posedge clk) disable iff (rst)
    roll_tick |-> $past(scan_tick));

  assert_scan_order_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(dig_en_n) && en_q != '1) |->
      dig_en_n == {en_q[DIGITS-2:0], en_q[DIGITS-1]});

  assert_one_cold_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_en_n));

  assert_blank_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (dig_en_n == '1) |-> seg_n == 7'b1111111);
endmodule

bind scroll_seg_display scroll_seg_checker #(.DIGITS(DIGITS)) chk_i (
  .clk(clk), .rst(rst), .dig_en_n(dig_en_n), .seg_n(seg_n),
  .scan_tick(scan_tick), .roll_tick(roll_tick)
);

// File: tb/scroll_seg_display_tb_top.sv
module scroll_seg_display_tb_top;
  localparam int unsigned SCAN   = 4;
  localparam int unsigned SCROLL = 3;
  localparam int NV = 13;

  // sample edge after reset release, expected enables, expected digit (15 = blank)
  localparam int VN  [NV] = '{4, 5, 9, 13, 14, 17, 21, 26, 50, 54, 62, 98, 110};
  localparam int VEN [NV] = '{15, 14, 13, 11, 11, 7, 14, 13, 7, 14, 11, 7, 11};
  localparam int VDIG[NV] = '{15, 4, 3, 2, 3, 2, 5, 5, 5, 0, 7, 1, 3};

  localparam logic [6:0] SEGTAB [16] = '{
    7'b1000000, 7'b1111001, 7'b0100100, 7'b0110000,
    7'b0011001, 7'b0010010, 7'b0000010, 7'b1111000,
    7'b0000000, 7'b0010000, 7'b1111111, 7'b1111111,
    7'b1111111, 7'b1111111, 7'b1111111, 7'b1111111};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] dig_en_n;
  logic [6:0] seg_n;
  int edge_n = 0;
  int n_chk = 0;
  int n_bad = 0;
  int cold_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  scroll_seg_display #(.SCAN_DIV(SCAN), .SCROLL_DIV(SCROLL)) dut_i (
    .clk(clk), .rst(rst), .dig_en_n(dig_en_n), .seg_n(seg_n)
  );

  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  always @(negedge clk) begin
    if (!rst && $countones(~dig_en_n) > 1) cold_bad++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edge_n);
    end
  endtask

  task automatic wait_edge(input int n);
    while (edge_n < n) @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dig_en_n == 4'b1111, "R1 enables in reset", dig_en_n, 4'hF);
    check(seg_n == 7'b1111111, "R1 R6 segments in reset", seg_n, 7'h7F);
    rst = 1'b0;

    // table walk: R2 R3 R4 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wait_edge(VN[i]);
      check(dig_en_n == 4'(VEN[i]), "R2 R4 enable pattern", dig_en_n, VEN[i]);
      check(seg_n == SEGTAB[VDIG[i]], "R3 R7 R8 R9 segments", seg_n, SEGTAB[VDIG[i]]);
    end

    // R5: never more than one digit lit over the whole run
    check(cold_bad == 0, "R5 one-cold violations", cold_bad, 0);

    // R1 mid-run reset, R7 ring restored
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(dig_en_n == 4'b1111, "R1 enables after mid-run reset", dig_en_n, 4'hF);
    check(seg_n == 7'b1111111, "R1 R6 blank after mid-run reset", seg_n, 7'h7F);
    rst = 1'b0;
    wait_edge(4);
    check(dig_en_n == 4'b1111, "R2 no early step", dig_en_n, 4'hF);
    wait_edge(5);
    check(seg_n == SEGTAB[4], "R7 ring reloaded", seg_n, SEGTAB[4]);
    wait_edge(13);
    check(seg_n == SEGTAB[2], "R3 no early rotation", seg_n, SEGTAB[2]);
    wait_edge(14);
    check(seg_n == SEGTAB[3], "R3 rotation edge", seg_n, SEGTAB[3]);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", edge_n);
      report();
    end
  end
endmodule